// File: doc/BRIEF.md
# Region-Based Virtual Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address (1 GB) using 512-byte pages and one single-level page table per region. The two top address bits pick the region. The upper half of the space is a shared system region. Its table is read straight from physical memory at a configured physical base. The lower half holds two per-process regions. Their tables live in system virtual space, so the address of a process page-table entry (PTE) must first be mapped through the system table. A process translation is therefore a chain of two memory reads.

A CPU-side requester offers one virtual address at a time on a valid/ready request channel. The block walks the tables through a read-only memory port, which has a valid/ready request and a separate response strobe. It then returns the physical address, or a fault code, with a one-cycle response pulse. Region bases and lengths arrive as static configuration inputs and must not change while a translation is in flight.

The control is a single walk state machine with five states:
- **IDLE**: waits for a request and accepts it (IDLE→DECODE).
- **DECODE**: classifies the address. It ends the walk with a fault (DECODE→DONE), starts a system-PTE read for a system address (DECODE→LEAF), or starts the read of the system PTE that maps a process table (DECODE→TABLE).
- **TABLE**: waits for that read. It faults (TABLE→DONE) or starts the final PTE read (TABLE→LEAF).
- **LEAF**: waits for the final PTE and forms the result (LEAF→DONE).
- **DONE**: emits the response pulse (DONE→IDLE).

A small read-port sequencer handles the memory handshake. It has three states: free, requesting and awaiting data.

Top module: `xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and both `rsp_valid` and `mem_rd_valid` are 0.
- R2: Virtual bits 31:30 select the region: 00 is process region A, 01 is process region B, 10 is the system region. The value 11 is reserved and completes with fault code 1 after no memory read.
- R3: On success `rsp_fault` is 0 and `rsp_paddr` is {final PTE frame, virtual bits 8:0}. Bits 8:0 pass through untranslated. On any fault `rsp_paddr` is 0.
- R4: A system-region address makes exactly one read, at `sys_base` + 4 × (virtual bits 29:9), modulo 2^30.
- R5: A process-region address first forms the table address T = region base + 4 × (virtual bits 29:9), modulo 2^32. It then makes exactly two reads, in this order: the system PTE at `sys_base` + 4 × T[29:9], and then the process PTE at {that PTE's frame, T[8:0]}.
- R6: A page number (virtual bits 29:9) not below its region's length register completes with fault code 2 after no memory read.
- R7: For a process address, a table address T with bits 31:30 other than 10, or with T[29:9] not below `sys_len`, completes with fault code 3 after no memory read.
- R8: A PTE is valid when bit 31 is 1 and carries its frame number in bits 20:0. An invalid system PTE that maps a process table gives fault code 4 after one read. An invalid final PTE gives fault code 5.
- R9: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the request and its address hold. A new read is issued only after the previous response strobe.
- R10: Only one translation is in flight at a time. `req_ready` is 0 from the cycle after acceptance until the cycle after the response. `rsp_valid` is a single-cycle pulse, given exactly once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_base | input | 30 | Physical byte address of the system page table |
| sys_len | input | 22 | Number of system-region pages mapped |
| pa_base | input | 32 | System-virtual address of region A's table |
| pa_len | input | 22 | Number of region A pages mapped |
| pb_base | input | 32 | System-virtual address of region B's table |
| pb_len | input | 22 | Number of region B pages mapped |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Translator free to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 3 | 0 ok, 1 reserved, 2 length, 3 table address, 4 table page, 5 page |
| rsp_paddr | output | 30 | Physical address, zero on fault |
| mem_rd_valid | output | 1 | PTE read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 30 | Physical byte address of the PTE |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | PTE word read |

## Verification
The hardest situations to reach are the deep faults on the chained process path. An invalid system PTE behind a process table, and an invalid final PTE after a successful first hop, each need a whole chain of memory contents to be set up consistently. The bench's memory model returns a valid, address-derived PTE by default. The stimulus then overrides single words, found by walking the same chain in the bench model, so that only the intended hop fails. Table-address faults are reached by reprogramming a process base into the lower half, or by shrinking the system length below the table's page. All of this runs under both free and throttled memory-ready patterns and with response latencies of one to three cycles.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int unsigned VA_W      = 32;
    localparam int unsigned PA_W      = 30;
    localparam int unsigned OFS_W     = 9;
    localparam int unsigned RGN_W     = 2;
    localparam int unsigned VPN_W     = VA_W - RGN_W - OFS_W;
    localparam int unsigned PFN_W     = PA_W - OFS_W;
    localparam int unsigned LEN_W     = VPN_W + 1;
    localparam int unsigned PTE_W     = 32;
    localparam int unsigned PTE_V_BIT = 31;
    localparam int unsigned ENT_LOG2  = 2;

    typedef enum logic [RGN_W-1:0] {
        RGN_PROC_A   = 2'b00,
        RGN_PROC_B   = 2'b01,
        RGN_SYSTEM   = 2'b10,
        RGN_RESERVED = 2'b11
    } region_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_RSVD    = 3'd1,
        FLT_LEN     = 3'd2,
        FLT_TBL_ADR = 3'd3,
        FLT_TBL_PG  = 3'd4,
        FLT_PAGE    = 3'd5
    } fault_e;

    typedef struct packed {
        logic             valid;
        logic [PFN_W-1:0] pfn;
    } pte_t;

    function automatic logic [PA_W-1:0] entry_pa(input logic [PA_W-1:0]  base,
                                                 input logic [VPN_W-1:0] idx);
        return base + PA_W'({idx, {ENT_LOG2{1'b0}}});
    endfunction
endpackage

// File: rtl/xlate_region_sel.sv
module xlate_region_sel
    import xlate_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PA_W-1:0]  sys_base,
    input  logic [LEN_W-1:0] sys_len,
    input  logic [VA_W-1:0]  pa_base,
    input  logic [LEN_W-1:0] pa_len,
    input  logic [VA_W-1:0]  pb_base,
    input  logic [LEN_W-1:0] pb_len,
    output region_e          rgn,
    output logic             len_fault,
    output logic             tbl_fault,
    output logic [PA_W-1:0]  sys_pte_pa,
    output logic [PA_W-1:0]  tbl_pte_pa,
    output logic [OFS_W-1:0] tbl_off
);
    logic [VPN_W-1:0] vpn;
    logic [LEN_W-1:0] sel_len;
    logic [VA_W-1:0]  sel_tbl;
    logic [VA_W-1:0]  tbl_va;
    logic [VPN_W-1:0] tbl_vpn;

    assign rgn = region_e'(vaddr[VA_W-1 -: RGN_W]);
    assign vpn = vaddr[VA_W-RGN_W-1 -: VPN_W];

    always_comb begin
        unique case (rgn)
            RGN_PROC_A: begin sel_len = pa_len;  sel_tbl = pa_base; end
            RGN_PROC_B: begin sel_len = pb_len;  sel_tbl = pb_base; end
            RGN_SYSTEM: begin sel_len = sys_len; sel_tbl = '0;      end
            default:    begin sel_len = '0;      sel_tbl = '0;      end
        endcase
    end

    assign len_fault  = {1'b0, vpn} >= sel_len;
    assign sys_pte_pa = entry_pa(sys_base, vpn);

    assign tbl_va  = sel_tbl + VA_W'({vpn, {ENT_LOG2{1'b0}}});
    assign tbl_vpn = tbl_va[VA_W-RGN_W-1 -: VPN_W];
    assign tbl_off = tbl_va[OFS_W-1:0];

    assign tbl_fault  = (region_e'(tbl_va[VA_W-1 -: RGN_W]) != RGN_SYSTEM) ||
                        ({1'b0, tbl_vpn} >= sys_len);
    assign tbl_pte_pa = entry_pa(sys_base, tbl_vpn);
endmodule

// File: rtl/xlate_pte_unpack.sv
module xlate_pte_unpack
    import xlate_pkg::*;
(
    input  logic [PTE_W-1:0] word,
    output pte_t             pte
);
    logic pte_unused;

    assign pte.valid  = word[PTE_V_BIT];
    assign pte.pfn    = word[PFN_W-1:0];
    assign pte_unused = &{1'b0, word[PTE_V_BIT-1:PFN_W]};
endmodule

// File: rtl/xlate_mem_rd.sv
module xlate_mem_rd
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PA_W-1:0]  start_addr,
    output logic             mem_rd_valid,
    input  logic             mem_rd_ready,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             done,
    output logic [PTE_W-1:0] data
);
    typedef enum logic [1:0] {M_FREE, M_ASK, M_AWAIT} mst_e;

    mst_e            mst, mst_nx;
    logic [PA_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mst <= M_FREE;
        else        mst <= mst_nx;
    end

    always_comb begin
        mst_nx = mst;
        unique case (mst)
            M_FREE:  if (start) mst_nx = M_ASK;
            M_ASK:   if (mem_rd_ready) mst_nx = M_AWAIT;
            M_AWAIT: if (mem_rsp_valid) mst_nx = start ? M_ASK : M_FREE;
            default: mst_nx = M_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     addr_q <= '0;
        else if (start) addr_q <= start_addr;
    end

    assign mem_rd_valid = (mst == M_ASK);
    assign mem_rd_addr  = addr_q;
    assign done         = (mst == M_AWAIT) && mem_rsp_valid;
    assign data         = mem_rsp_data;

    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    a_r9_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (mst == M_FREE) || done);
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xlate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PA_W-1:0]       sys_base,
    input  logic [LEN_W-1:0]      sys_len,
    input  logic [VA_W-1:0]       pa_base,
    input  logic [LEN_W-1:0]      pa_len,
    input  logic [VA_W-1:0]       pb_base,
    input  logic [LEN_W-1:0]      pb_len,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_vaddr,
    output logic                  rsp_valid,
    output logic [2:0]            rsp_fault,
    output logic [PA_W-1:0]       rsp_paddr,
    output logic                  mem_rd_valid,
    input  logic                  mem_rd_ready,
    output logic [PA_W-1:0]       mem_rd_addr,
    input  logic                  mem_rsp_valid,
    input  logic [PTE_W-1:0]      mem_rsp_data
);
    typedef enum logic [2:0] {S_IDLE, S_DECODE, S_TABLE, S_LEAF, S_DONE} st_e;

    st_e              st, st_nx;
    logic [VA_W-1:0]  va_q;
    logic [OFS_W-1:0] tbl_off_q;
    fault_e           fault_q;
    logic [PA_W-1:0]  paddr_q;

    region_e          rgn;
    logic             len_fault, tbl_fault;
    logic [PA_W-1:0]  sys_pte_pa, tbl_pte_pa;
    logic [OFS_W-1:0] tbl_off;

    logic             mem_start, mem_done;
    logic [PA_W-1:0]  mem_addr;
    logic [PTE_W-1:0] mem_data;
    pte_t             pte;

    logic             res_we;
    fault_e           res_fault;
    logic [PA_W-1:0]  res_paddr;

    xlate_region_sel u_rgn (
        .vaddr      (va_q),
        .sys_base   (sys_base),
        .sys_len    (sys_len),
        .pa_base    (pa_base),
        .pa_len     (pa_len),
        .pb_base    (pb_base),
        .pb_len     (pb_len),
        .rgn        (rgn),
        .len_fault  (len_fault),
        .tbl_fault  (tbl_fault),
        .sys_pte_pa (sys_pte_pa),
        .tbl_pte_pa (tbl_pte_pa),
        .tbl_off    (tbl_off)
    );

    xlate_mem_rd u_mem (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (mem_start),
        .start_addr    (mem_addr),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (mem_done),
        .data          (mem_data)
    );

    xlate_pte_unpack u_pte (
        .word (mem_data),
        .pte  (pte)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // transitions and per-state actions
    always_comb begin
        st_nx     = st;
        mem_start = 1'b0;
        mem_addr  = '0;
        res_we    = 1'b0;
        res_fault = FLT_NONE;
        res_paddr = '0;
        unique case (st)
            S_IDLE: begin
                if (req_valid) st_nx = S_DECODE;
            end
            S_DECODE: begin
                if (rgn == RGN_RESERVED) begin
                    res_we = 1'b1; res_fault = FLT_RSVD; st_nx = S_DONE;
                end else if (len_fault) begin
                    res_we = 1'b1; res_fault = FLT_LEN; st_nx = S_DONE;
                end else if (rgn == RGN_SYSTEM) begin
                    mem_start = 1'b1; mem_addr = sys_pte_pa; st_nx = S_LEAF;
                end else if (tbl_fault) begin
                    res_we = 1'b1; res_fault = FLT_TBL_ADR; st_nx = S_DONE;
                end else begin
                    mem_start = 1'b1; mem_addr = tbl_pte_pa; st_nx = S_TABLE;
                end
            end
            S_TABLE: begin
                if (mem_done) begin
                    if (!pte.valid) begin
                        res_we = 1'b1; res_fault = FLT_TBL_PG; st_nx = S_DONE;
                    end else begin
                        mem_start = 1'b1;
                        mem_addr  = {pte.pfn, tbl_off_q};
                        st_nx     = S_LEAF;
                    end
                end
            end
            S_LEAF: begin
                if (mem_done) begin
                    res_we = 1'b1;
                    st_nx  = S_DONE;
                    if (!pte.valid) res_fault = FLT_PAGE;
                    else            res_paddr = {pte.pfn, va_q[OFS_W-1:0]};
                end
            end
            S_DONE: st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q      <= '0;
            tbl_off_q <= '0;
            fault_q   <= FLT_NONE;
            paddr_q   <= '0;
        end else begin
            if (st == S_IDLE && req_valid) va_q <= req_vaddr;
            if (st == S_DECODE)            tbl_off_q <= tbl_off;
            if (res_we) begin
                fault_q <= res_fault;
                paddr_q <= res_paddr;
            end
        end
    end

    assign req_ready = (st == S_IDLE);
    assign rsp_valid = (st == S_DONE);
    assign rsp_fault = fault_q;
    assign rsp_paddr = paddr_q;

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r10_busy_at_response: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r3_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault != 3'd0) |-> (rsp_paddr == '0));

    a_r6_no_read_while_decoding: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DECODE) |-> !mem_rd_valid);

    a_r10_no_read_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_valid);
endmodule

// File: tb/test_xlate_walker.sv
module test_xlate_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] sys_base;
    logic [21:0] sys_len;
    logic [31:0] pa_base, pb_base;
    logic [21:0] pa_len, pb_len;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_fault;
    logic [29:0] rsp_paddr;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [29:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] pmem [bit [29:0]];
    logic [29:0] seen_q[$];
    int          stall_mode = 0;
    int          lat = 1;
    int          cyc = 0;

    always #10 clk = ~clk;

    xlate_walker i_xlate_walker (
        .clk(clk), .rst_n(rst_n),
        .sys_base(sys_base), .sys_len(sys_len),
        .pa_base(pa_base), .pa_len(pa_len),
        .pb_base(pb_base), .pb_len(pb_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [29:0] a);
        if (pmem.exists(a)) return pmem[a];
        return {1'b1, 10'd0, a[22:2] ^ 21'h15A5A};
    endfunction

    // behavioural reference
    function automatic void model(input logic [31:0] va, output logic [2:0] f,
                                  output logic [29:0] pa, output int n,
                                  output logic [29:0] a0, output logic [29:0] a1);
        logic [20:0] vpn;
        logic [21:0] len;
        logic [31:0] tva, w;
        f = 0; pa = 0; n = 0; a0 = 0; a1 = 0;
        vpn = va[29:9];
        len = (va[31:30] == 2'b00) ? pa_len : (va[31:30] == 2'b01) ? pb_len : sys_len;
        if (va[31:30] == 2'b11) begin f = 1; return; end
        if ({1'b0, vpn} >= len) begin f = 2; return; end
        if (va[31:30] == 2'b10) begin
            a0 = sys_base + {7'd0, vpn, 2'b00};
            n = 1;
            w = rd(a0);
            if (!w[31]) f = 5; else pa = {w[20:0], va[8:0]};
            return;
        end
        tva = ((va[31:30] == 2'b00) ? pa_base : pb_base) + {9'd0, vpn, 2'b00};
        if (tva[31:30] != 2'b10 || {1'b0, tva[29:9]} >= sys_len) begin f = 3; return; end
        a0 = sys_base + {7'd0, tva[29:9], 2'b00};
        n = 1;
        w = rd(a0);
        if (!w[31]) begin f = 4; return; end
        a1 = {w[20:0], tva[8:0]};
        n = 2;
        w = rd(a1);
        if (!w[31]) f = 5; else pa = {w[20:0], va[8:0]};
    endfunction

    // memory responder, driven away from the active edge
    bit          hs_prev = 0, hold_prev = 0;
    logic [29:0] addr_prev = '0, resp_addr = '0;
    int          cnt = 0;
    always @(negedge clk) begin
        cyc++;
        mem_rsp_valid = 1'b0;
        if (!rst_n) begin
            mem_rd_ready = 1'b0; hs_prev = 0; hold_prev = 0; cnt = 0;
        end else begin
            if (hold_prev) begin
                chk(mem_rd_valid === 1'b1, "R9", "request dropped while stalled", {31'd0, mem_rd_valid}, 1);
                chk(mem_rd_addr === addr_prev, "R9", "address moved while stalled", {2'd0, mem_rd_addr}, {2'd0, addr_prev});
            end
            if (hs_prev) begin
                seen_q.push_back(addr_prev);
                resp_addr = addr_prev;
                cnt = lat;
            end
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(resp_addr);
                end
            end
            mem_rd_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) == 2);
            hs_prev   = mem_rd_valid && mem_rd_ready;
            hold_prev = mem_rd_valid && !mem_rd_ready;
            addr_prev = mem_rd_addr;
        end
    end

    task automatic xlate(input logic [31:0] va);
        logic [2:0]  ef;
        logic [29:0] ep, a0, a1;
        int          en;
        string       tag;
        bit          got;
        model(va, ef, ep, en, a0, a1);
        case (ef)
            3'd1: tag = "R2";
            3'd2: tag = "R6";
            3'd3: tag = "R7";
            3'd4, 3'd5: tag = "R8";
            default: tag = (va[31:30] == 2'b10) ? "R4" : "R5";
        endcase
        @(negedge clk);
        chk(req_ready === 1'b1, "R10", "ready before request", {31'd0, req_ready}, 1);
        seen_q.delete();
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        got = 0;
        for (int i = 0; i < 60; i++) begin
            if (rsp_valid === 1'b1) begin got = 1; break; end
            chk(req_ready === 1'b0, "R10", "ready while busy", {31'd0, req_ready}, 0);
            @(negedge clk);
        end
        chk(got, "R10", "response pulse missing", {31'd0, got}, 1);
        if (got) begin
            chk(rsp_fault === ef, tag, "fault code", {29'd0, rsp_fault}, {29'd0, ef});
            chk(rsp_paddr === ep, (ef == 0) ? "R3" : "R3", "physical address", {2'd0, rsp_paddr}, {2'd0, ep});
            chk(seen_q.size() == en, tag, "number of reads", seen_q.size(), en);
            if (en >= 1 && seen_q.size() >= 1)
                chk(seen_q[0] === a0, tag, "first read address", {2'd0, seen_q[0]}, {2'd0, a0});
            if (en == 2 && seen_q.size() == 2)
                chk(seen_q[1] === a1, "R5", "second read address", {2'd0, seen_q[1]}, {2'd0, a1});
            @(negedge clk);
            chk(rsp_valid === 1'b0, "R10", "pulse longer than one cycle", {31'd0, rsp_valid}, 0);
            chk(req_ready === 1'b1, "R10", "ready after response", {31'd0, req_ready}, 1);
        end
    endtask

    function automatic logic [29:0] leaf_of_a(input logic [20:0] vpn);
        logic [31:0] tva, w;
        tva = pa_base + {9'd0, vpn, 2'b00};
        w = rd(sys_base + {7'd0, tva[29:9], 2'b00});
        return {w[20:0], tva[8:0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] x;
        sys_base = 30'h0010_0000; sys_len = 22'd4096;
        pa_base  = 32'h8000_4000; pa_len  = 22'd512;
        pb_base  = 32'h8000_8000; pb_len  = 22'd256;
        pmem[sys_base + 30'd28]        = 32'h0;           // system page 7 invalid
        pmem[sys_base + 30'(4 * 'h23)] = 32'h0;           // region A table page 3 invalid
        pmem[sys_base + 30'(4 * 'h41)] = 32'h0;           // region B table page 1 invalid
        pmem[leaf_of_a(21'd10)]        = 32'h7FFF_FFFF;   // region A page 10 invalid (bit31 clear)
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1, "R1", "req_ready in reset", {31'd0, req_ready}, 1);
        chk(rsp_valid === 1'b0, "R1", "rsp_valid in reset", {31'd0, rsp_valid}, 0);
        chk(mem_rd_valid === 1'b0, "R1", "mem_rd_valid in reset", {31'd0, mem_rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_rd_valid === 1'b0,
            "R1", "state after reset", {29'd0, req_ready, rsp_valid, mem_rd_valid}, 32'b100);

        for (int sm = 0; sm < 2; sm++) begin
            for (int l = 1; l <= 3; l++) begin
                stall_mode = sm; lat = l;
                xlate(32'h8000_0000);   // R4 first system page
                xlate(32'h8000_21AB);   // R4 offset pass-through
                xlate(32'h801F_FFFF);   // R4 last mapped system page
                xlate(32'h8020_0000);   // R6 system length edge
                xlate(32'h8000_0E10);   // R8 invalid system leaf
                xlate(32'hC000_0000);   // R2 reserved
                xlate(32'hFFFF_FFFF);   // R2 reserved
                xlate(32'h0000_0000);   // R5 region A page 0
                xlate(32'h0000_15F3);   // R5 region A page 10 invalid leaf (R8)
                xlate(32'h0000_0200 + 32'd511); // R5 region A
                xlate(32'h0003_FFFF);   // R8 region A page 511, table page invalid
                xlate(32'h0004_0000);   // R6 region A length edge
                xlate(32'h4000_0123);   // R5 region B page 0
                xlate(32'h4000_FE01);   // R5 region B page 127
                xlate(32'h4001_0000);   // R8 region B page 128 table page invalid
                xlate(32'h4002_0000);   // R6 region B length edge
            end
        end

        // R7 table address outside system region
        stall_mode = 0; lat = 1;
        pb_base = 32'h0000_1000;
        xlate(32'h4000_0000);
        pb_base = 32'h8000_8000;
        // R7 table page beyond system length
        sys_len = 22'h40;
        xlate(32'h4000_0400);
        xlate(32'h8000_7E00);   // R4 last page under shrunk length
        xlate(32'h8000_8000);   // R6 first page over shrunk length
        sys_len = 22'd4096;

        // mixed stream
        x = 32'h1234_5678;
        for (int k = 0; k < 60; k++) begin
            x = x * 32'd1103515245 + 32'd12345;
            stall_mode = k % 2;
            lat = 1 + (k % 3);
            xlate({x[31:30], 12'd0, x[20:12], x[8:0]});
        end

        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule